// File: doc/BRIEF.md
# Programmable Eight-Input Interrupt Controller

This block gathers eight interrupt request lines and presents them to a processor as one interrupt line plus an 8-bit vector. A small register port lets software set it up. The port has one address bit, an 8-bit write bus and an 8-bit read bus. Inside, the block keeps:

- a mask register;
- an in-service register;
- a latch of rising edges, one bit per input;
- a rotating priority pointer. The pointer names the level that currently has top priority, and the other levels follow it in ascending order, wrapping modulo 8.

After reset, software sends an initialisation sequence. A command byte at address 0 starts it, and one to three bytes at address 1 follow. Once the sequence is complete, further bytes written to address 0 are operation commands: end-of-interrupt, priority rotation and read-mode selection. Writes to address 1 then load the mask.

When the controller is ready and a request is pending, unmasked and not blocked by an in-service level of higher or equal priority, the interrupt output goes high. The processor answers with a one-cycle acknowledge strobe. The controller returns the vector in that same cycle and moves the chosen level into service. As an alternative, a poll mode lets the processor read the pending level from the data port instead of using the interrupt line.

Top module: `pirq_ctrl`

## Requirements
- R1: After reset the controller is not ready. INT is low and the mask reads 0x00. The stored read mode is 0x02 (request register readback), and the request readback shows 0x00.
- R2: In edge mode, a level becomes pending only after its input goes from 0 to 1, and only while that input stays high. Holding an input high after its request has been acknowledged does not request again.
- R3: In level mode (write-0 command bit 3 set), a high input is pending for as long as it stays high, with no edge needed.
- R4: When ready, INT is high exactly when the scan finds a pending, unmasked level. The scan walks levels from the priority pointer upward and stops at the first level found in service. That level and every level after it in the order are blocked.
- R5: An acknowledge strobe returns vector {base[7:3], level} for the level the scan picks, in the same cycle. It clears that level's edge latch bit. It sets the level's in-service bit unless automatic end-of-interrupt was enabled (bit 1 of the optional last setup byte).
- R6: A write to address 0 with bit 4 set starts initialisation. It clears the mask, the in-service bits and the edge latches, and it leaves the controller not ready.
- R7: Setup bytes then go to address 1 in this order: the vector base; then one ignored byte, only when command bit 1 was clear (cascade); then the option byte, only when command bit 0 was set. After the last of these, the controller is ready. Until it is ready, INT stays low.
- R8: Address-0 writes with bits 4:3 = 00 are operation commands. Bits 7:5 give the opcode and bits 2:0 give the level. Opcode 001 clears the first in-service bit found from the pointer. Opcode 011 clears the named level's in-service bit. Opcodes 010 and 100 do nothing.
- R9: Opcode 101 acts like 001 and also advances the pointer by one, modulo 8. Opcode 110 loads the pointer with the level. Opcode 111 works only if the named level is in service: it clears that in-service bit and the level's latch, and it advances the pointer.
- R10: Address-0 writes with bits 4:3 = 01 set the read mode. While bit 2 (poll) is set, INT stays low. A read at address 0 then acknowledges the scanned level and returns 0x80 | level, or returns 0x00 if no level qualifies.
- R11: With poll clear, a read at address 0 depends on mode bits 1:0. The value 10 returns the pending requests. The value 11 returns in-service AND NOT mask. Any other value returns 0x00.
- R12: When ready, a write to address 1 loads the mask and a read at address 1 returns it. A masked level does not raise INT, but it still appears in the request readback.
- R13: When an acknowledge and a rising edge on another input fall in the same cycle, the new edge is kept. If a rising edge and a latch clear hit the same bit, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (needed for poll side effect) |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of the read |
| irq_in | input | 8 | Interrupt request inputs |
| int_o | output | 1 | Interrupt request to the processor |
| ack_i | input | 1 | One-cycle interrupt acknowledge strobe |
| vector_o | output | 8 | Vector for the acknowledged level, valid while ack_i is high |

## Verification
Two things can land on the edge-latch register in the same clock: an acknowledge that clears the latch of the level being served, and a fresh rising edge on another input. The bench drives the acknowledge strobe on the same clock in which a new input goes high. It checks three things: the vector comes from the level that was already latched; INT stays high straight after the acknowledge; the next acknowledge returns the newly risen level. An assertion in the edge stage also checks that every rising edge shows up in the latch on the following cycle, whatever clears land in the same cycle.

// File: rtl/pirq_pkg.sv
`timescale 1ns/1ps
package pirq_pkg;
    localparam int IRQ_N  = 8;
    localparam int LVL_W  = $clog2(IRQ_N);
    localparam int DW     = 8;
    localparam int BASE_W = DW - LVL_W;
    localparam int MODE_W = 3;

    // operation opcodes carried in bits 7:5 of an address-0 write
    localparam logic [2:0] OP_EOI_SCAN  = 3'b001;
    localparam logic [2:0] OP_EOI_NAMED = 3'b011;
    localparam logic [2:0] OP_ROT_SCAN  = 3'b101;
    localparam logic [2:0] OP_SET_PTR   = 3'b110;
    localparam logic [2:0] OP_ROT_NAMED = 3'b111;

    localparam logic [MODE_W-1:0] MODE_RESET = 3'b010;

    typedef enum logic [2:0] {
        ST_WAIT_CMD,
        ST_WAIT_BASE,
        ST_WAIT_CASC,
        ST_WAIT_OPT,
        ST_READY
    } init_st_e;

    typedef struct packed {
        init_st_e             st;
        logic [LVL_W-1:0]     ptr;
        logic [IRQ_N-1:0]     isr;
        logic [IRQ_N-1:0]     mask;
        logic [BASE_W-1:0]    base;
        logic [MODE_W-1:0]    mode;
        logic                 lvl_mode;
        logic                 single;
        logic                 need_opt;
        logic                 auto_eoi;
    } ctl_regs_t;
endpackage

// File: rtl/pirq_edge.sv
`timescale 1ns/1ps
module pirq_edge
    import pirq_pkg::*;
#(
    parameter int N = IRQ_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] clr,
    input  logic         level_mode,
    output logic [N-1:0] req_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] latch;
    } edge_regs_t;

    edge_regs_t q, d;
    logic [N-1:0] rise;

    always_comb begin
        rise    = irq_in & ~q.prev;
        d.prev  = irq_in;
        // a fresh rise wins over a clear in the same cycle
        d.latch = (q.latch & ~clr) | rise;
        req_o   = level_mode ? irq_in : (q.latch & irq_in);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R2, R13: every rising input is held in the latch one cycle later
    p_rise_kept_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((q.latch & $past(rise)) == $past(rise)));
endmodule

// File: rtl/pirq_scan.sv
`timescale 1ns/1ps
module pirq_scan
    import pirq_pkg::*;
#(
    parameter int N = IRQ_N,
    parameter int W = LVL_W
) (
    input  logic [W-1:0] start,
    input  logic [N-1:0] block,
    input  logic [N-1:0] want,
    output logic         hit,
    output logic [W-1:0] lvl
);
    logic         stop;
    logic [W-1:0] idx;

    always_comb begin
        hit  = 1'b0;
        lvl  = '0;
        stop = 1'b0;
        idx  = '0;
        for (int k = 0; k < N; k++) begin
            idx = start + k[W-1:0];
            if (!stop && !hit) begin
                if (block[idx]) begin
                    stop = 1'b1;
                end else if (want[idx]) begin
                    hit = 1'b1;
                    lvl = idx;
                end
            end
        end
    end
endmodule

// File: rtl/pirq_ctrl.sv
`timescale 1ns/1ps
module pirq_ctrl
    import pirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [IRQ_N-1:0] irq_in,
    output logic             int_o,
    input  logic             ack_i,
    output logic [DW-1:0]    vector_o
);
    ctl_regs_t q, d;

    logic [IRQ_N-1:0] req;
    logic [IRQ_N-1:0] latch_clr;
    logic             cand_hit;
    logic [LVL_W-1:0] cand_lvl;
    logic             eoi_hit;
    logic [LVL_W-1:0] eoi_lvl;
    logic             poll;
    logic             take;
    logic [LVL_W-1:0] wl;

    pirq_edge #(.N(IRQ_N)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .clr        (latch_clr),
        .level_mode (q.lvl_mode),
        .req_o      (req)
    );

    // level to serve: pending, unmasked, not behind an in-service level
    pirq_scan #(.N(IRQ_N), .W(LVL_W)) u_cand (
        .start (q.ptr),
        .block (q.isr),
        .want  (req & ~q.mask),
        .hit   (cand_hit),
        .lvl   (cand_lvl)
    );

    // first in-service level in rotating order, for the scanning EOI forms
    pirq_scan #(.N(IRQ_N), .W(LVL_W)) u_eoi (
        .start (q.ptr),
        .block ('0),
        .want  (q.isr),
        .hit   (eoi_hit),
        .lvl   (eoi_lvl)
    );

    always_comb begin
        d         = q;
        latch_clr = '0;
        poll      = q.mode[2];
        wl        = wdata[LVL_W-1:0];
        take      = ack_i | (rd_en & ~addr & poll);

        if (take && cand_hit) begin
            latch_clr[cand_lvl] = 1'b1;
            if (!q.auto_eoi) begin
                d.isr[cand_lvl] = 1'b1;
            end
        end

        if (wr_en) begin
            if (!addr) begin
                if (wdata[4]) begin
                    d.isr      = '0;
                    d.mask     = '0;
                    latch_clr  = '1;
                    d.lvl_mode = wdata[3];
                    d.single   = wdata[1];
                    d.need_opt = wdata[0];
                    d.st       = ST_WAIT_BASE;
                end else if (wdata[3]) begin
                    d.mode = wdata[MODE_W-1:0];
                end else begin
                    unique case (wdata[7:5])
                        OP_EOI_SCAN: begin
                            if (eoi_hit) d.isr[eoi_lvl] = 1'b0;
                        end
                        OP_EOI_NAMED: begin
                            d.isr[wl] = 1'b0;
                        end
                        OP_ROT_SCAN: begin
                            if (eoi_hit) begin
                                d.isr[eoi_lvl] = 1'b0;
                                d.ptr          = q.ptr + LVL_W'(1);
                            end
                        end
                        OP_SET_PTR: begin
                            d.ptr = wl;
                        end
                        OP_ROT_NAMED: begin
                            if (q.isr[wl]) begin
                                d.isr[wl]     = 1'b0;
                                latch_clr[wl] = 1'b1;
                                d.ptr         = q.ptr + LVL_W'(1);
                            end
                        end
                        default: ;
                    endcase
                end
            end else begin
                unique case (q.st)
                    ST_WAIT_BASE: begin
                        d.base = wdata[DW-1:LVL_W];
                        if (!q.single)     d.st = ST_WAIT_CASC;
                        else if (q.need_opt) d.st = ST_WAIT_OPT;
                        else               d.st = ST_READY;
                    end
                    ST_WAIT_CASC: begin
                        d.st = q.need_opt ? ST_WAIT_OPT : ST_READY;
                    end
                    ST_WAIT_OPT: begin
                        d.auto_eoi = wdata[1];
                        d.st       = ST_READY;
                    end
                    ST_READY: begin
                        d.mask = wdata;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        int_o    = (q.st == ST_READY) && cand_hit && !poll;
        vector_o = (ack_i && cand_hit) ? {q.base, cand_lvl} : '0;
        if (addr) begin
            rdata = q.mask;
        end else if (poll) begin
            rdata = cand_hit ? {1'b1, {(DW-1-LVL_W){1'b0}}, cand_lvl} : '0;
        end else begin
            unique case (q.mode[1:0])
                2'b10:   rdata = req;
                2'b11:   rdata = q.isr & ~q.mask;
                default: rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_WAIT_CMD;
            q.mode <= MODE_RESET;
        end else begin
            q <= d;
        end
    end

    // R5: an acknowledged level enters service unless auto end-of-interrupt
    p_ack_serves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && cand_hit && !q.auto_eoi && !wr_en) |=> q.isr[$past(cand_lvl)]);

    // R5: a new in-service bit only ever follows an acknowledge or poll read
    p_isr_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(q.isr & ~$past(q.isr))) |-> $past(take && cand_hit));

    // R6: the initialisation command empties mask and in-service state
    p_init_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4]) |=> (q.isr == '0 && q.mask == '0 && !int_o));

    // R8: a named end-of-interrupt leaves that level out of service
    p_named_eoi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[7:3] == {OP_EOI_NAMED, 2'b00} && !take)
        |=> !q.isr[$past(wdata[LVL_W-1:0])]);

    // R9: the pointer load takes the level field
    p_ptr_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[7:3] == {OP_SET_PTR, 2'b00}) |=> q.ptr == $past(wdata[LVL_W-1:0]));

    // R12: a mask write in the ready state is read back
    p_mask_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && q.st == ST_READY) |=> q.mask == $past(wdata));
endmodule

// File: tb/sim_pirq_ctrl.sv
`timescale 1ns/1ps
module sim_pirq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       addr = 1'b0;
    logic       ack_i = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] irq_in = 8'h00;
    logic [7:0] rdata;
    logic [7:0] vector_o;
    logic       int_o;

    always #4 clk = ~clk;

    pirq_ctrl u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .irq_in   (irq_in),
        .int_o    (int_o),
        .ack_i    (ack_i),
        .vector_o (vector_o)
    );

    typedef enum {K_RD, K_VEC, K_INT} kind_e;
    typedef struct {
        kind_e      kind;
        logic [7:0] exp;
        string      tag;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // monitor: compare queued expectations well before the next rising edge
    always @(negedge clk) begin
        #2;
        while (sb.size() > 0) begin
            exp_t       it;
            logic [7:0] act;
            it = sb.pop_front();
            case (it.kind)
                K_RD:    act = rdata;
                K_VEC:   act = vector_o;
                default: act = {7'b0, int_o};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(input kind_e k, input logic [7:0] e, input string t);
        exp_t it;
        it.kind = k;
        it.exp  = e;
        it.tag  = t;
        sb.push_back(it);
    endtask

    task automatic wr(input logic a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, input logic [7:0] e, input string t);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        push(K_RD, e, t);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic ack(input logic [7:0] e, input string t);
        @(negedge clk);
        ack_i = 1'b1;
        push(K_VEC, e, t);
        @(posedge clk); #1;
        ack_i = 1'b0;
    endtask

    task automatic ack_with_irq(input logic [7:0] nirq, input logic [7:0] e, input string t);
        @(negedge clk);
        ack_i = 1'b1; irq_in = nirq;
        push(K_VEC, e, t);
        @(posedge clk); #1;
        ack_i = 1'b0;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
    endtask

    task automatic chk_int(input logic e, input string t);
        @(negedge clk);
        push(K_INT, {7'b0, e}, t);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (every requirement): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // reset state
        chk_int(1'b0, "R1 int low after reset");
        rd(1'b1, 8'h00, "R1 mask after reset");
        rd(1'b0, 8'h00, "R1 request readback after reset");

        // single, edge, option byte follows; base 0x20; no auto-EOI
        wr(1'b0, 8'h13);
        wr(1'b1, 8'h20);
        wr(1'b1, 8'h01);

        set_irq(8'h08);
        chk_int(1'b1, "R2 rise on level 3 raises int");
        rd(1'b0, 8'h08, "R11 request readback");
        ack(8'h23, "R5 vector base plus level 3");
        chk_int(1'b0, "R5 int drops after ack");
        wr(1'b0, 8'h0B);
        rd(1'b0, 8'h08, "R11 in-service readback");

        set_irq(8'h28);
        chk_int(1'b0, "R4 level 5 blocked by level 3 in service");
        set_irq(8'h2A);
        chk_int(1'b1, "R4 level 1 outranks in-service level 3");
        ack(8'h21, "R4 vector for level 1");
        rd(1'b0, 8'h0A, "R5 both levels in service");

        wr(1'b0, 8'h20);
        chk_int(1'b0, "R8 scan EOI leaves level 3 blocking");
        rd(1'b0, 8'h08, "R8 scan EOI cleared level 1");
        wr(1'b0, 8'h20);
        chk_int(1'b1, "R8 second scan EOI frees level 5");
        ack(8'h25, "R8 vector for level 5");
        wr(1'b0, 8'h65);
        rd(1'b0, 8'h00, "R8 named EOI cleared level 5");
        wr(1'b0, 8'h40);
        rd(1'b0, 8'h00, "R8 opcode 010 changes nothing");
        chk_int(1'b0, "R2 held inputs do not request again");
        wr(1'b0, 8'h0A);
        rd(1'b0, 8'h00, "R2 request empty while inputs held");

        // mask
        set_irq(8'h00);
        wr(1'b1, 8'h04);
        rd(1'b1, 8'h04, "R12 mask readback");
        set_irq(8'h04);
        chk_int(1'b0, "R12 masked level silent");
        rd(1'b0, 8'h04, "R12 masked level still requested");
        wr(1'b1, 8'h00);
        chk_int(1'b1, "R12 unmask raises int");

        // acknowledge with a new rise on level 1 in the same cycle
        ack_with_irq(8'h06, 8'h22, "R13 vector from latched level 2");
        chk_int(1'b1, "R13 new edge on level 1 kept");
        ack(8'h21, "R13 second ack serves level 1");
        wr(1'b0, 8'h20);
        wr(1'b0, 8'h20);
        wr(1'b0, 8'h0B);
        rd(1'b0, 8'h00, "R8 two scan EOIs empty service");

        // rotation
        set_irq(8'h00);
        wr(1'b0, 8'hC6);
        set_irq(8'h81);
        chk_int(1'b1, "R9 pending after pointer load");
        ack(8'h27, "R9 pointer 6 ranks level 7 over 0");
        chk_int(1'b0, "R9 level 0 blocked by level 7");
        wr(1'b0, 8'hA0);
        chk_int(1'b1, "R9 rotating EOI frees level 0");
        ack(8'h20, "R9 vector for level 0");
        wr(1'b0, 8'hE0);
        rd(1'b0, 8'h00, "R9 named rotate cleared level 0");
        set_irq(8'h00);
        set_irq(8'h81);
        ack(8'h20, "R9 pointer wrapped to 0");
        chk_int(1'b0, "R9 level 7 blocked behind level 0");
        wr(1'b0, 8'h60);
        ack(8'h27, "R9 level 7 after named EOI");
        wr(1'b0, 8'h67);

        // poll
        set_irq(8'h00);
        wr(1'b0, 8'h0C);
        set_irq(8'h10);
        chk_int(1'b0, "R10 poll keeps int low");
        rd(1'b0, 8'h84, "R10 poll read returns level 4");
        rd(1'b0, 8'h00, "R10 poll read with nothing to serve");
        wr(1'b0, 8'h0B);
        rd(1'b0, 8'h10, "R10 poll read put level 4 in service");
        wr(1'b0, 8'h08);
        rd(1'b0, 8'h00, "R11 read mode 00 returns zero");

        // re-initialise: level mode, cascade, option byte with auto-EOI
        wr(1'b1, 8'hF0);
        rd(1'b1, 8'hF0, "R12 mask loaded before reinit");
        wr(1'b0, 8'h19);
        rd(1'b1, 8'h00, "R6 init clears mask");
        wr(1'b0, 8'h0B);
        rd(1'b0, 8'h00, "R6 init clears in-service");
        chk_int(1'b0, "R7 int low awaiting base");
        wr(1'b1, 8'h40);
        wr(1'b1, 8'hFF);
        chk_int(1'b0, "R7 int low awaiting option byte");
        wr(1'b1, 8'h02);
        chk_int(1'b1, "R3 held level input pending");
        ack(8'h44, "R7 new base applied");
        rd(1'b0, 8'h00, "R5 auto-EOI leaves no service bit");
        chk_int(1'b1, "R3 level stays pending while high");
        set_irq(8'h00);
        chk_int(1'b0, "R3 level released");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule